// File: doc/BRIEF.md
# Multiplierless Lifting 8-Point DCT Engine

This block is the transform stage of a JPEG-style encoder. It takes one row or column of eight signed, level-shifted samples and produces eight coefficients that approximate a one-dimensional 8-point DCT. Every rotation in the transform is split into a predict step and an update step. Each coefficient in those steps is a sum of powers of one half, so a product becomes a sum of arithmetically right-shifted copies of its operand. The whole datapath uses adders and shifters only, on integers. It has no multiplier and no fractional arithmetic.

A caller presents the eight samples on one flat bus and pulses `start_i` while the engine is idle. A sequencer with nine states (one idle state and eight work states) runs the network one stage per cycle: an input butterfly, the even butterfly, lifting on both halves, and a second odd butterfly. The engine then writes all eight coefficients at once and raises `done_o` for one cycle. The coefficients are left unscaled on purpose, because the quantizer that follows absorbs the per-coefficient scale factors. Each lifting coefficient is a module parameter, given as a list of shift amounts.

Top module: `dct8_lift_core`

## Requirements
- R1: While reset is applied and after it is released, `done_o` is 0 and every coefficient on `coef_o` is 0 until the first result is written.
- R2: A `start_i` seen high in the idle state on a rising edge captures `samples_i`. `done_o` is then high for exactly the one cycle that follows the eighth rising edge after that capture edge, and low in every other cycle.
- R3: All internal values and outputs are signed, DW = IW+4 bits wide. No input combination overflows, including all-minimum and all-maximum samples.
- R4: Coefficient 0 equals the sum of the eight samples.
- R5: Let a_k = x_k + x_(7-k), c0 = a0+a3, c1 = a1+a2, c2 = a1-a2 and c3 = a0-a3. The even coefficients are then: coefficient 4 = floor(coef0/2) - c1; coefficient 6 = c2 - [c3]PE; coefficient 2 = c3 + [coef6]UE.
- R6: Let b_k = x_k - x_(7-k), p = b2 - [b1]PA, q = b1 + [p]UA, e0 = b0+q, e1 = b0-q, e2 = b3-p and e3 = b3+p. The odd coefficients are then: coefficient 7 = e3 - [e0]PB; coefficient 1 = e0 + [coef7]UB; coefficient 3 = e2 - [e1]PC; coefficient 5 = e1 + [coef3]UC.
- R7: [v]S is the sum of v >>> s over the shift list S, and each term rounds toward negative infinity. The default lists are PE = UE = {2,3}, PA = {2,3,5}, UA = {1,3,4}, PB = UB = {3,4}, PC = {1,2,3} and UC = {1}. A shift of 0 marks an unused slot.
- R8: `start_i` has no effect while a transform is in progress. The running result, the timing of its `done_o` pulse and the absence of any further `done_o` pulse are all unaffected.
- R9: `coef_o` holds its value from one result write to the next, whatever happens on `samples_i` and during the following transform.
- R10: Sample k sits at `samples_i[k*IW +: IW]` and coefficient k at `coef_o[k*DW +: DW]`. Both are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start a transform; acted on only when idle |
| samples_i | input | 8*IW | Eight signed input samples, sample k in slice k |
| done_o | output | 1 | One-cycle pulse when a new set of coefficients is written |
| coef_o | output | 8*DW | Eight signed unscaled coefficients, coefficient k in slice k |

## Verification
The bench builds the engine with IW = 4 and DW = 8, so each sample has only sixteen values. That makes it practical to sweep every value at every sample position against two backgrounds, to try all 256 sign patterns of minimum and maximum samples, and to run every constant vector. The negative cases exercise the floor behaviour of each shift in every lifting product. The headroom of DW is also tested at the point where it is tightest. The expected coefficients come from a shift-and-add evaluation of the network written in the bench. That evaluation is followed by random vectors, a start pulse issued in the middle of a transform, and a check that the outputs hold between results.

// File: rtl/dct8_lift_pkg.sv
package dct8_lift_pkg;
  localparam int unsigned SHIFT_SLOTS = 4;
  localparam int unsigned SHIFT_W     = 4;

  // slot value 0 = slot unused
  typedef logic [SHIFT_SLOTS-1:0][SHIFT_W-1:0] shift_list_t;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_BFLY_IN,
    ST_BFLY_EVEN,
    ST_LIFT_1,
    ST_LIFT_2,
    ST_LIFT_3,
    ST_LIFT_4,
    ST_LIFT_5,
    ST_WRITE
  } state_t;
endpackage

// File: rtl/dct8_lift_step.sv
module dct8_lift_step
  import dct8_lift_pkg::*;
#(
  parameter int unsigned DW       = 12,
  parameter shift_list_t SHIFTS   = '0,
  parameter bit          SUBTRACT = 1'b0
) (
  input  logic signed [DW-1:0] base_i,
  input  logic signed [DW-1:0] src_i,
  output logic signed [DW-1:0] res_o
);
  logic signed [DW-1:0] term [SHIFT_SLOTS];
  logic signed [DW-1:0] prod;

  for (genvar i = 0; i < SHIFT_SLOTS; i++) begin : g_term
    if (SHIFTS[i] == '0) begin : g_off
      assign term[i] = '0;
    end else begin : g_on
      assign term[i] = src_i >>> SHIFTS[i];
    end
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < SHIFT_SLOTS; i++) prod = prod + term[i];
  end

  if (SUBTRACT) begin : g_pred
    assign res_o = base_i - prod;
  end else begin : g_upd
    assign res_o = base_i + prod;
  end
endmodule

// File: rtl/dct8_lift_fsm.sv
module dct8_lift_fsm
  import dct8_lift_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output state_t state_o,
  output logic   done_o
);
  state_t state_q, state_d;
  logic   done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:      if (start_i) state_d = ST_BFLY_IN;
      ST_BFLY_IN:   state_d = ST_BFLY_EVEN;
      ST_BFLY_EVEN: state_d = ST_LIFT_1;
      ST_LIFT_1:    state_d = ST_LIFT_2;
      ST_LIFT_2:    state_d = ST_LIFT_3;
      ST_LIFT_3:    state_d = ST_LIFT_4;
      ST_LIFT_4:    state_d = ST_LIFT_5;
      ST_LIFT_5:    state_d = ST_WRITE;
      ST_WRITE:     state_d = ST_INIT;
      default:      state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WRITE);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dct8_lift_core.sv
module dct8_lift_core
  import dct8_lift_pkg::*;
#(
  parameter int unsigned IW         = 8,
  parameter int unsigned DW         = IW + 4,
  parameter shift_list_t PRED_EVEN  = {4'd0, 4'd0, 4'd3, 4'd2},
  parameter shift_list_t UPD_EVEN   = {4'd0, 4'd0, 4'd3, 4'd2},
  parameter shift_list_t PRED_A     = {4'd0, 4'd5, 4'd3, 4'd2},
  parameter shift_list_t UPD_A      = {4'd0, 4'd4, 4'd3, 4'd1},
  parameter shift_list_t PRED_B     = {4'd0, 4'd0, 4'd4, 4'd3},
  parameter shift_list_t UPD_B      = {4'd0, 4'd0, 4'd4, 4'd3},
  parameter shift_list_t PRED_C     = {4'd0, 4'd3, 4'd2, 4'd1},
  parameter shift_list_t UPD_C      = {4'd0, 4'd0, 4'd0, 4'd1}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [8*IW-1:0] samples_i,
  output logic            done_o,
  output logic [8*DW-1:0] coef_o
);
  localparam int unsigned N    = 8;
  localparam int unsigned HALF = N / 2;

  state_t state;

  logic signed [DW-1:0] smp_ext [N];
  logic signed [DW-1:0] x_q     [N];
  logic signed [DW-1:0] a_q     [HALF];
  logic signed [DW-1:0] b_q     [HALF];
  logic signed [DW-1:0] c_q     [HALF];
  logic signed [DW-1:0] e_q     [HALF];
  logic signed [DW-1:0] w_q     [N];
  logic signed [DW-1:0] coef_q  [N];
  logic signed [DW-1:0] p_q, q_q;

  logic signed [DW-1:0] pa_res, ua_res, pe_res, ue_res;
  logic signed [DW-1:0] pb_res, ub_res, pc_res, uc_res;

  dct8_lift_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .done_o  (done_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_io
    assign smp_ext[k] = {{(DW-IW){samples_i[k*IW+IW-1]}}, samples_i[k*IW +: IW]};
    assign coef_o[k*DW +: DW] = coef_q[k];
  end

  // odd rotation A on (b2, b1)
  dct8_lift_step #(.DW(DW), .SHIFTS(PRED_A), .SUBTRACT(1'b1)) u_pa (
    .base_i(b_q[2]), .src_i(b_q[1]), .res_o(pa_res));
  dct8_lift_step #(.DW(DW), .SHIFTS(UPD_A), .SUBTRACT(1'b0)) u_ua (
    .base_i(b_q[1]), .src_i(p_q), .res_o(ua_res));
  // even rotation on (c2, c3)
  dct8_lift_step #(.DW(DW), .SHIFTS(PRED_EVEN), .SUBTRACT(1'b1)) u_pe (
    .base_i(c_q[2]), .src_i(c_q[3]), .res_o(pe_res));
  dct8_lift_step #(.DW(DW), .SHIFTS(UPD_EVEN), .SUBTRACT(1'b0)) u_ue (
    .base_i(c_q[3]), .src_i(w_q[6]), .res_o(ue_res));
  // odd rotation B on (e3, e0)
  dct8_lift_step #(.DW(DW), .SHIFTS(PRED_B), .SUBTRACT(1'b1)) u_pb (
    .base_i(e_q[3]), .src_i(e_q[0]), .res_o(pb_res));
  dct8_lift_step #(.DW(DW), .SHIFTS(UPD_B), .SUBTRACT(1'b0)) u_ub (
    .base_i(e_q[0]), .src_i(w_q[7]), .res_o(ub_res));
  // odd rotation C on (e2, e1)
  dct8_lift_step #(.DW(DW), .SHIFTS(PRED_C), .SUBTRACT(1'b1)) u_pc (
    .base_i(e_q[2]), .src_i(e_q[1]), .res_o(pc_res));
  dct8_lift_step #(.DW(DW), .SHIFTS(UPD_C), .SUBTRACT(1'b0)) u_uc (
    .base_i(e_q[1]), .src_i(w_q[3]), .res_o(uc_res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) begin
        x_q[k]    <= '0;
        w_q[k]    <= '0;
        coef_q[k] <= '0;
      end
      for (int k = 0; k < HALF; k++) begin
        a_q[k] <= '0;
        b_q[k] <= '0;
        c_q[k] <= '0;
        e_q[k] <= '0;
      end
      p_q <= '0;
      q_q <= '0;
    end else begin
      unique case (state)
        ST_INIT: begin
          if (start_i) begin
            for (int k = 0; k < N; k++) x_q[k] <= smp_ext[k];
          end
        end
        ST_BFLY_IN: begin
          for (int k = 0; k < HALF; k++) begin
            a_q[k] <= x_q[k] + x_q[N-1-k];
            b_q[k] <= x_q[k] - x_q[N-1-k];
          end
        end
        ST_BFLY_EVEN: begin
          c_q[0] <= a_q[0] + a_q[3];
          c_q[1] <= a_q[1] + a_q[2];
          c_q[2] <= a_q[1] - a_q[2];
          c_q[3] <= a_q[0] - a_q[3];
        end
        ST_LIFT_1: begin
          w_q[0] <= c_q[0] + c_q[1];
          p_q    <= pa_res;
        end
        ST_LIFT_2: begin
          w_q[4] <= (w_q[0] >>> 1) - c_q[1];
          w_q[6] <= pe_res;
          q_q    <= ua_res;
        end
        ST_LIFT_3: begin
          w_q[2] <= ue_res;
          e_q[0] <= b_q[0] + q_q;
          e_q[1] <= b_q[0] - q_q;
          e_q[2] <= b_q[3] - p_q;
          e_q[3] <= b_q[3] + p_q;
        end
        ST_LIFT_4: begin
          w_q[7] <= pb_res;
          w_q[3] <= pc_res;
        end
        ST_LIFT_5: begin
          w_q[1] <= ub_res;
          w_q[5] <= uc_res;
        end
        ST_WRITE: begin
          for (int k = 0; k < N; k++) coef_q[k] <= w_q[k];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dct8_lift_chk.sv
module dct8_lift_chk
  import dct8_lift_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned DW = IW + 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            done_o,
  input logic [8*DW-1:0] coef_o,
  input state_t          state_i
);
  localparam int DC_MAX = 8 * ((1 << (IW-1)) - 1);
  localparam int DC_MIN = -8 * (1 << (IW-1));

  logic [3:0] since_q;
  logic signed [DW-1:0] dc;
  assign dc = $signed(coef_o[DW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (state_i == ST_INIT && start_i) since_q <= 4'd1;
    else if (since_q != 4'd0 && since_q != 4'd15) since_q <= since_q + 4'd1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> since_q == 4'd9); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_INIT) |=> (state_i != ST_BFLY_IN)); // R8
  AST_COEF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(coef_o)); // R9
  AST_DC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(dc) <= DC_MAX && int'(dc) >= DC_MIN)); // R3
endmodule

bind dct8_lift_core dct8_lift_chk #(.IW(IW), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .coef_o  (coef_o),
  .state_i (state)
);

// File: tb/tb_dct8_lift_core.sv
module tb_dct8_lift_core;
  localparam int IW = 4;
  localparam int DW = 8;
  localparam int VMIN = -(1 << (IW-1));
  localparam int VMAX = (1 << (IW-1)) - 1;

  typedef int vec_t [8];

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [8*IW-1:0] samples_i = '0;
  logic            done_o;
  logic [8*DW-1:0] coef_o;

  int errors = 0;
  int checks = 0;
  vec_t prev_y;
  bit   have_prev = 1'b0;
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  always #4 clk = ~clk; // 125 MHz

  dct8_lift_core #(.IW(IW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .samples_i(samples_i), .done_o(done_o), .coef_o(coef_o));

  function automatic int coef(int k);
    logic signed [DW-1:0] v;
    v = coef_o[k*DW +: DW];
    return int'(v);
  endfunction

  function automatic string req_of(int k);
    if (k == 0) return "R4";
    if (k % 2 == 0) return "R5";
    return "R6";
  endfunction

  // shift-sum products, floor rounding (R7)
  function automatic int m_pe(int v); return (v >>> 2) + (v >>> 3); endfunction
  function automatic int m_pa(int v); return (v >>> 2) + (v >>> 3) + (v >>> 5); endfunction
  function automatic int m_ua(int v); return (v >>> 1) + (v >>> 3) + (v >>> 4); endfunction
  function automatic int m_pb(int v); return (v >>> 3) + (v >>> 4); endfunction
  function automatic int m_pc(int v); return (v >>> 1) + (v >>> 2) + (v >>> 3); endfunction
  function automatic int m_uc(int v); return v >>> 1; endfunction

  function automatic vec_t model(vec_t x);
    vec_t y;
    int a [4], b [4], c0, c1, c2, c3, p, q, e0, e1, e2, e3;
    for (int k = 0; k < 4; k++) begin
      a[k] = x[k] + x[7-k];
      b[k] = x[k] - x[7-k];
    end
    c0 = a[0] + a[3]; c1 = a[1] + a[2]; c2 = a[1] - a[2]; c3 = a[0] - a[3];
    y[0] = c0 + c1;
    y[4] = (y[0] >>> 1) - c1;
    y[6] = c2 - m_pe(c3);
    y[2] = c3 + m_pe(y[6]);
    p = b[2] - m_pa(b[1]);
    q = b[1] + m_ua(p);
    e0 = b[0] + q; e1 = b[0] - q; e2 = b[3] - p; e3 = b[3] + p;
    y[7] = e3 - m_pb(e0);
    y[1] = e0 + m_pb(y[7]);
    y[3] = e2 - m_pc(e1);
    y[5] = e1 + m_uc(y[3]);
    return y;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t s);
    for (int k = 0; k < 8; k++) samples_i[k*IW +: IW] = s[k][IW-1:0];
  endtask

  // disturb: issue a start with other samples mid-transform (R8)
  task automatic run_xform(vec_t s, string tag, bit disturb);
    vec_t y, other;
    y = model(s);
    for (int k = 0; k < 8; k++) other[k] = VMAX - ((s[k] - VMIN) % 16);
    @(negedge clk);
    drive(s);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb && i == 3) begin
        drive(other);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (i == 4 && have_prev)
        for (int k = 0; k < 8; k++) check("R9", "hold mid-run", coef(k), prev_y[k]);
    end
    check("R2", "done early", int'(done_o), 0);
    @(posedge clk);
    @(negedge clk);
    check("R2", "done pulse", int'(done_o), 1);
    for (int k = 0; k < 8; k++) begin
      check(req_of(k), $sformatf("coef%0d (%s)", k, tag), coef(k), y[k]);
    end
    @(posedge clk);
    @(negedge clk);
    check("R2", "done width", int'(done_o), 0);
    prev_y = y;
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    vec_t s;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) check("R1", "coef in reset", coef(k), 0);
    check("R1", "done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "done after reset", int'(done_o), 0);
    for (int k = 0; k < 8; k++) check("R1", "coef after reset", coef(k), 0);

    // constant vectors, negative ones exercise floor shifts (R7)
    for (int v = VMIN; v <= VMAX; v++) begin
      for (int k = 0; k < 8; k++) s[k] = v;
      run_xform(s, "R7 const", 1'b0);
    end
    // every value at every position, two backgrounds (R10)
    for (int bg = 0; bg < 2; bg++)
      for (int pos = 0; pos < 8; pos++)
        for (int v = VMIN; v <= VMAX; v++) begin
          for (int k = 0; k < 8; k++) s[k] = (bg == 0) ? 0 : VMIN;
          s[pos] = v;
          run_xform(s, "R10 walk", 1'b0);
        end
    // all min/max sign patterns (R3)
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 8; k++) s[k] = m[k] ? VMAX : VMIN;
      run_xform(s, "R3 extremes", 1'b0);
    end
    // pseudo-random
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < 8; k++) begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        s[k] = int'($signed(lfsr[IW-1:0]));
      end
      run_xform(s, "random", 1'b0);
    end
    // start while busy (R8)
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 8; k++) s[k] = ((k * 5 + n * 3) % 16) + VMIN;
      run_xform(s, "R8 busy start", 1'b1);
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        check("R8", "no second done", int'(done_o), 0);
      end
    end
    // outputs held while idle with moving inputs (R9)
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      samples_i = samples_i ^ 32'h5a5a_a5a5;
      for (int k = 0; k < 8; k++) check("R9", "hold idle", coef(k), prev_y[k]);
      check("R9", "idle done", int'(done_o), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule